// File: doc/BRIEF.md
# Ready-valid FIFO with arbitrary capacity

A synchronous first-in first-out queue with a valid/ready handshake on both its producer side and its consumer side. Storage is a circular memory whose depth is any nonzero number, including values that are not powers of two. The write pointer and the read pointer step back to slot zero after the last slot. A count output gives the number of words currently held. That value can reach the full depth, so it is one bit wider than a pointer when the depth is a power of two.

Two build-time switches each add one combinational path, giving four configurations. With the ready switch set, a full queue raises its input ready in any cycle where the consumer is taking a word. A new word then enters in the same cycle that a slot is freed. With the valid switch set, an empty queue presents a word from its input straight to its output in the same cycle. If the consumer takes that word, it is never counted as held.

A debug window returns the word stored in any slot chosen by an index input. It also returns the current write pointer and read pointer, so that an observer can track the queue's state.

Top module: `rv_fifo`

## Requirements
- R1: After reset the count is 0, both pointers are 0, and output valid is low while input valid is low.
- R2: Words leave in exactly the order in which they were accepted, and no word is lost or duplicated.
- R3: A transfer on the input side alone raises the count by one. A transfer on the output side alone lowers it by one. Transfers on both sides, or on neither, leave it unchanged.
- R4: The count never exceeds DEPTH. Input ready is high whenever the count is below DEPTH. When COMB_READY is 0, input ready is low whenever the count equals DEPTH.
- R5: With COMB_VALID at 0, output valid is high exactly when the count is nonzero.
- R6: Each pointer advances by one on a transfer on its own side and goes from DEPTH-1 back to 0.
- R7: With COMB_READY at 1 and the queue full, input ready follows output ready. When output ready is high, a word is accepted while the oldest word leaves, and the count stays at DEPTH.
- R8: With COMB_VALID at 1 and the queue empty, output valid follows input valid and the output data equals the input data in that cycle. A word taken in that cycle leaves the count at 0.
- R9: The debug data output equals the last word written into the slot selected by the debug index. The write pointer and read pointer outputs equal the pointer values.
- R10: The count never underflows: a transfer on the output side happens only when output valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Producer offers a word |
| inReady | output | 1 | Queue can take a word |
| inData | input | DATA_W | Word offered by the producer |
| outValid | output | 1 | Queue offers a word |
| outReady | input | 1 | Consumer takes the offered word |
| outData | output | DATA_W | Word offered to the consumer |
| count | output | $clog2(DEPTH+1) | Number of words held |
| dbgIndex | input | IDX_W | Slot selected for debug read |
| dbgData | output | DATA_W | Word stored in the selected slot |
| dbgWrIdx | output | IDX_W | Current write pointer |
| dbgRdIdx | output | IDX_W | Current read pointer |

## Verification
The queue is filled to capacity with the consumer stalled and then drained with the producer idle. This separates the full and empty boundaries from the ordinary state. A long stretch with random valid and ready on both sides makes the pointers wrap many times at the non-power-of-two depth. That stretch also mixes one-sided and two-sided transfers, so a wrong step of the count or a wrong wrap point shows up as out-of-order data or a count mismatch. A second instance with both bypass paths enabled receives directed patterns. In one, a word is offered to the empty queue with the consumer ready. In the other, a word is offered to the full queue while the consumer takes the head. These two patterns tell the combinational paths apart from the registered behaviour.

// File: rtl/rv_fifo_pkg.sv
package rv_fifo_pkg;
  typedef struct packed {
    logic push;    // word written into the slot at the write pointer
    logic pop;     // word taken by the consumer
    logic bypass;  // output data taken straight from the input
  } fifoStrobes_t;
endpackage

// File: rtl/rv_fifo_ctrl.sv
module rv_fifo_ctrl
  import rv_fifo_pkg::*;
#(
  parameter int DEPTH      = 5,
  parameter bit COMB_READY = 1'b0,
  parameter bit COMB_VALID = 1'b0,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output fifoStrobes_t     stb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic isFull;
  logic isEmpty;

  assign isFull  = (count == FULL_CNT);
  assign isEmpty = (count == '0);

  generate
    if (COMB_READY) begin : g_combReady
      assign inReady = !isFull || outReady;
    end else begin : g_regReady
      assign inReady = !isFull;
    end

    if (COMB_VALID) begin : g_combValid
      assign outValid   = !isEmpty || inValid;
      assign stb.bypass = isEmpty;
    end else begin : g_regValid
      assign outValid   = !isEmpty;
      assign stb.bypass = 1'b0;
    end
  endgenerate

  assign stb.push = inValid && inReady;
  assign stb.pop  = outValid && outReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      wrIdx <= '0;
      rdIdx <= '0;
    end else begin
      if (stb.push) begin
        wrIdx <= (wrIdx == LAST_IDX) ? '0 : wrIdx + 1'b1;
      end
      if (stb.pop) begin
        rdIdx <= (rdIdx == LAST_IDX) ? '0 : rdIdx + 1'b1;
      end
      case ({stb.push, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rv_fifo_dp.sv
module rv_fifo_dp
  import rv_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 5,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  fifoStrobes_t      stb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] inData,
  input  logic [IDX_W-1:0]  dbgIndex,
  output logic [DATA_W-1:0] outData,
  output logic [DATA_W-1:0] dbgData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.push) begin
      mem[wrIdx] <= inData;
    end
  end

  assign outData = stb.bypass ? inData : mem[rdIdx];
  assign dbgData = (int'(dbgIndex) < DEPTH) ? mem[dbgIndex] : '0;
endmodule

// File: rtl/rv_fifo.sv
module rv_fifo
  import rv_fifo_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 5,
  parameter bit COMB_READY = 1'b0,
  parameter bit COMB_VALID = 1'b0,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic [CNT_W-1:0]  count,
  input  logic [IDX_W-1:0]  dbgIndex,
  output logic [DATA_W-1:0] dbgData,
  output logic [IDX_W-1:0]  dbgWrIdx,
  output logic [IDX_W-1:0]  dbgRdIdx
);
  fifoStrobes_t stb;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;

  rv_fifo_ctrl #(
    .DEPTH(DEPTH), .COMB_READY(COMB_READY), .COMB_VALID(COMB_VALID)
  ) ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .count(count),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .stb(stb)
  );

  rv_fifo_dp #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) dp_i (
    .clk(clk), .stb(stb), .wrIdx(wrIdx), .rdIdx(rdIdx), .inData(inData),
    .dbgIndex(dbgIndex), .outData(outData), .dbgData(dbgData)
  );

  assign dbgWrIdx = wrIdx;
  assign dbgRdIdx = rdIdx;
endmodule

// File: rtl/rv_fifo_chk.sv
module rv_fifo_chk #(
  parameter int DEPTH      = 5,
  parameter bit COMB_READY = 1'b0,
  parameter bit COMB_VALID = 1'b0,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [CNT_W-1:0] count,
  input logic [IDX_W-1:0] dbgWrIdx,
  input logic [IDX_W-1:0] dbgRdIdx
);
  logic inFire;
  logic outFire;
  assign inFire  = inValid && inReady;
  assign outFire = outValid && outReady;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (count == '0 && dbgWrIdx == '0 && dbgRdIdx == '0));

  a_r3_count_inc: assert property (@(posedge clk) disable iff (rst)
    (inFire && !outFire) |=> count == CNT_W'($past(count) + 1'b1));

  a_r3_count_dec: assert property (@(posedge clk) disable iff (rst)
    (!inFire && outFire) |=> count == CNT_W'($past(count) - 1'b1));

  a_r3_count_hold: assert property (@(posedge clk) disable iff (rst)
    (inFire == outFire) |=> $stable(count));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  a_r4_ready_below_full: assert property (@(posedge clk) disable iff (rst)
    (count < CNT_W'(DEPTH)) |-> inReady);

  a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !inValid) |-> !outFire);

  a_r6_wr_wrap: assert property (@(posedge clk) disable iff (rst)
    (inFire && dbgWrIdx == IDX_W'(DEPTH - 1)) |=> dbgWrIdx == '0);

  a_r6_rd_wrap: assert property (@(posedge clk) disable iff (rst)
    (outFire && dbgRdIdx == IDX_W'(DEPTH - 1)) |=> dbgRdIdx == '0);

  generate
    if (COMB_READY) begin : g_chkReady
      a_r7_full_pass: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH) && outReady) |-> inReady);
    end else begin : g_chkNoReady
      a_r4_full_block: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) |-> !inReady);
    end
    if (COMB_VALID) begin : g_chkValid
      a_r8_empty_pass: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && inValid) |-> outValid);
    end else begin : g_chkNoValid
      a_r5_valid_iff_data: assert property (@(posedge clk) disable iff (rst)
        outValid == (count != '0));
    end
  endgenerate
endmodule

bind rv_fifo rv_fifo_chk #(
  .DEPTH(DEPTH), .COMB_READY(COMB_READY), .COMB_VALID(COMB_VALID)
) chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .count(count),
  .dbgWrIdx(dbgWrIdx), .dbgRdIdx(dbgRdIdx)
);

// File: tb/rv_fifo_tb_top.sv
module rv_fifo_tb_top;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 5;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  // registered configuration
  logic              inValid = 1'b0, outReady = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic [IDX_W-1:0]  dbgIndex = '0;
  logic              inReady, outValid;
  logic [DATA_W-1:0] outData, dbgData;
  logic [CNT_W-1:0]  count;
  logic [IDX_W-1:0]  dbgWrIdx, dbgRdIdx;

  // bypass configuration
  logic              cInValid = 1'b0, cOutReady = 1'b0;
  logic [DATA_W-1:0] cInData = '0;
  logic              cInReady, cOutValid;
  logic [DATA_W-1:0] cOutData, cDbgData;
  logic [CNT_W-1:0]  cCount;
  logic [IDX_W-1:0]  cWrIdx, cRdIdx;

  rv_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .COMB_READY(1'b0), .COMB_VALID(1'b0)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .count(count),
    .dbgIndex(dbgIndex), .dbgData(dbgData), .dbgWrIdx(dbgWrIdx), .dbgRdIdx(dbgRdIdx));

  rv_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .COMB_READY(1'b1), .COMB_VALID(1'b1)) dut_c (
    .clk(clk), .rst(rst), .inValid(cInValid), .inReady(cInReady), .inData(cInData),
    .outValid(cOutValid), .outReady(cOutReady), .outData(cOutData), .count(cCount),
    .dbgIndex('0), .dbgData(cDbgData), .dbgWrIdx(cWrIdx), .dbgRdIdx(cRdIdx));

  int nChecks = 0;
  int nFails  = 0;
  bit running = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard state for dut_i
  logic [DATA_W-1:0] expQ [$];
  logic [DATA_W-1:0] refMem [DEPTH];
  bit                refWritten [DEPTH];
  int refCount = 0, refWr = 0, refRd = 0;

  // monitor: samples 2 ns after the falling edge, when inputs have settled
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (running) begin
        logic [DATA_W-1:0] exp;
        bit inF, outF;
        check(int'(count) == refCount, "R3 count", int'(count), refCount);
        check(int'(count) <= DEPTH, "R4 bound", int'(count), DEPTH);
        check(inReady == (refCount < DEPTH), "R4 inReady", int'(inReady), int'(refCount < DEPTH));
        check(outValid == (refCount != 0), "R5 outValid", int'(outValid), int'(refCount != 0));
        check(int'(dbgWrIdx) == refWr, "R6 wr pointer", int'(dbgWrIdx), refWr);
        check(int'(dbgRdIdx) == refRd, "R6 rd pointer", int'(dbgRdIdx), refRd);
        if (refWritten[dbgIndex])
          check(dbgData == refMem[dbgIndex], "R9 debug word", int'(dbgData), int'(refMem[dbgIndex]));
        inF  = inValid && inReady;
        outF = outValid && outReady;
        if (outF) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R10 pop from empty", 1, 0);
          end else begin
            exp = expQ.pop_front();
            check(outData == exp, "R2 order", int'(outData), int'(exp));
          end
          refRd = (refRd == DEPTH - 1) ? 0 : refRd + 1;
        end
        if (inF) begin
          expQ.push_back(inData);
          refMem[refWr] = inData;
          refWritten[refWr] = 1'b1;
          refWr = (refWr == DEPTH - 1) ? 0 : refWr + 1;
        end
        if (inF && !outF) refCount++;
        if (!inF && outF) refCount--;
      end
    end
  end

  // driver: sets the inputs of dut_i for one cycle at the falling edge
  task automatic drive(input bit v, input logic [DATA_W-1:0] d, input bit r);
    @(negedge clk);
    inValid  = v;
    inData   = d;
    outReady = r;
    dbgIndex = IDX_W'($urandom_range(DEPTH - 1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    check(count == '0, "R1 count", int'(count), 0);
    check(!outValid, "R1 outValid", int'(outValid), 0);
    check(dbgWrIdx == '0 && dbgRdIdx == '0, "R1 pointers", int'(dbgWrIdx), 0);
    check(cCount == '0 && !cOutValid, "R1 bypass instance", int'(cCount), 0);
    running = 1'b1;

    // fill past capacity with the consumer stalled
    for (int i = 0; i < DEPTH + 3; i++) drive(1'b1, DATA_W'(8'h10 + i), 1'b0);
    // drain past empty with the producer idle
    for (int i = 0; i < DEPTH + 3; i++) drive(1'b0, '0, 1'b1);
    // steady stream on both sides
    for (int i = 0; i < 3 * DEPTH; i++) drive(1'b1, DATA_W'(8'h40 + i), 1'b1);
    // random traffic, wrapping both pointers many times
    for (int i = 0; i < 400; i++)
      drive(1'($urandom_range(1)), DATA_W'($urandom), 1'($urandom_range(1)));
    for (int i = 0; i < DEPTH + 2; i++) drive(1'b0, '0, 1'b1);
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b0;
    @(negedge clk);
    running = 1'b0;
    check(expQ.size() == 0, "R2 all words returned", expQ.size(), 0);

    // R8: empty bypass instance passes a word straight through
    @(negedge clk);
    cInValid = 1'b1; cInData = 8'hA5; cOutReady = 1'b1;
    #2;
    check(cOutValid, "R8 valid follows input", int'(cOutValid), 1);
    check(cOutData == 8'hA5, "R8 data passes through", int'(cOutData), 8'hA5);
    @(negedge clk);
    cInValid = 1'b0;
    #2;
    check(cCount == '0, "R8 count stays zero", int'(cCount), 0);
    check(!cOutValid, "R8 valid drops when input idle", int'(cOutValid), 0);

    // R7: fill the bypass instance, then push while popping at full
    cOutReady = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      cInValid = 1'b1; cInData = DATA_W'(8'h70 + i);
    end
    @(negedge clk);
    cInValid = 1'b1; cInData = 8'hEE; cOutReady = 1'b0;
    #2;
    check(int'(cCount) == DEPTH, "R7 full", int'(cCount), DEPTH);
    check(!cInReady, "R7 blocked when consumer stalled", int'(cInReady), 0);
    @(negedge clk);
    cOutReady = 1'b1;
    #2;
    check(cInReady, "R7 ready follows consumer", int'(cInReady), 1);
    check(cOutData == 8'h70, "R7 head leaves", int'(cOutData), 8'h70);
    @(negedge clk);
    cInValid = 1'b0; cOutReady = 1'b0;
    #2;
    check(int'(cCount) == DEPTH, "R7 count stays full", int'(cCount), DEPTH);
    check(cOutData == 8'h71, "R7 next head", int'(cOutData), 8'h71);
    for (int i = 1; i < DEPTH; i++) begin
      @(negedge clk);
      cOutReady = 1'b1;
    end
    @(negedge clk);
    cOutReady = 1'b0;
    #2;
    check(cOutData == 8'hEE, "R7 word taken at full kept in order", int'(cOutData), 8'hEE);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule